// File: doc/BRIEF.md
# Bundle Splitter and Group Issue Stage

This stage sits between instruction fetch and the execution ports of a statically scheduled core. Each fetch handshake delivers up to two 128-bit bundles. Every bundle carries three 41-bit instruction slots and a 5-bit template. The stage splits each bundle into its slots. It decodes the template into a unit class for each slot and into stop markers. A stop marks the boundary between groups of instructions that the compiler has declared safe to run together.

Decoded slots enter a small ordered buffer. Each cycle the stage hands the oldest buffered slots to up to six issue lanes. It never lets one cycle's issue reach past a stop, so the parallelism comes entirely from the encoded stops and not from any hazard analysis in hardware. A group may span a bundle boundary. Slots left behind by a stop wait in the buffer, and the fetch handshake is throttled until there is room. Bundles with a reserved template raise an error pulse and contribute no instructions. A flush input discards everything buffered, including the unissued tail of a group.

Top module: `bndl_issue`

## Requirements
- R1: Within a bundle, bits 4:0 hold the template, slot 0 is bits 45:5, slot 1 is bits 86:46 and slot 2 is bits 127:87. Each issued lane carries the slot bits unchanged on its 41-bit field of `iss_slot`.
- R2: Template bits 4:2 select the unit classes for slots 0,1,2: 0=M,I,I; 1=M,M,I; 2=M,F,I; 3=M,M,F; 4=M,I,B; 5=M,B,B; 6=B,B,B; 7=M,M,B. On `iss_unit`, M=0, I=1, F=2 and B=3.
- R3: Template bits 1:0 select the stops: 0 = no stop, 1 = stop after slot 2, 2 = stop after slot 0, 3 = stops after slot 1 and after slot 2.
- R4: Templates 22, 26 and 27 are reserved. An accepted bundle with a reserved template issues nothing, and `illegal_bundle` is high for exactly the cycle after the handshake. The other bundle of the same handshake is processed normally.
- R5: A handshake (`fetch_valid` and `fetch_ready` high at a clock edge) takes the bundles whose bit in `fetch_bmask` is set. Bundle 0 (bits 127:0 of `fetch_bundles`) is older than bundle 1 (bits 255:128).
- R6: At most six slots issue per cycle, and no slot after a stop issues in the same cycle as the slot carrying that stop. Slots without an intervening stop issue together, including across a bundle boundary, whenever they are buffered and a lane is free.
- R7: Lanes fill in program order from lane 0. Lane 0 carries the oldest slot, and the valid lanes are always a contiguous run starting at lane 0.
- R8: `fetch_ready` is high exactly when `flush` is low and no more than DEPTH-6 slots (6 with defaults) are buffered.
- R9: While `flush` is high, no lane is valid and `fetch_ready` is low. After the flush cycle the buffer is empty, and any partially issued group is dropped.
- R10: After reset no lane is valid, `fetch_ready` is high and `illegal_bundle` is low.
- R11: Slots taken at a clock edge can issue in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all buffered slots |
| fetch_valid | input | 1 | Fetch offers bundles |
| fetch_bmask | input | 2 | Per-bundle presence, bit 0 = bundle 0 |
| fetch_bundles | input | 256 | Bundle 1 in the upper half, bundle 0 in the lower half |
| fetch_ready | output | 1 | Stage can take a full handshake |
| iss_valid | output | 6 | Per-lane issue valid |
| iss_slot | output | 246 | Lane l's slot at bits 41*l+40 : 41*l |
| iss_unit | output | 12 | Lane l's unit class at bits 2*l+1 : 2*l |
| illegal_bundle | output | 1 | Reserved template seen in the previous handshake |

## Verification
The bench builds the stage with its defaults: six lanes, two bundles per handshake and a twelve-slot buffer. With a buffer only twice the handshake size, two back-to-back handshakes whose groups are cut early by stops push occupancy above six, so the throttling of `fetch_ready` is reached within a few cycles. Six lanes equal to one full handshake make it possible to issue a whole dual-bundle group in one cycle and to exercise groups that are cut at a stop in the middle of a bundle. A long random stream mixes every template and presence mask against an in-order scoreboard.

// File: rtl/bndl_pkg.sv
package bndl_pkg;
  localparam int SLOT_W   = 41;
  localparam int TMPL_W   = 5;
  localparam int BUNDLE_W = 128;
  localparam int SLOTS    = 3;

  typedef enum logic [1:0] {U_MEM = 2'd0, U_INT = 2'd1, U_FPU = 2'd2, U_BRN = 2'd3} unit_e;

  // one decoded instruction slot as held in the buffer
  typedef struct packed {
    logic [SLOT_W-1:0] bits;
    unit_e             unit;
    logic              stop;   // group ends after this slot
  } slot_t;

  typedef struct packed {
    logic                legal;
    unit_e [SLOTS-1:0]   unit;
    logic  [SLOTS-1:0]   stop;
  } tmpl_t;

  // template: [4:2] unit pattern, [1:0] stop placement
  function automatic tmpl_t decode_tmpl(logic [TMPL_W-1:0] t);
    tmpl_t d;
    case (t[4:2])
      3'd0:    begin d.unit[0] = U_MEM; d.unit[1] = U_INT; d.unit[2] = U_INT; end
      3'd1:    begin d.unit[0] = U_MEM; d.unit[1] = U_MEM; d.unit[2] = U_INT; end
      3'd2:    begin d.unit[0] = U_MEM; d.unit[1] = U_FPU; d.unit[2] = U_INT; end
      3'd3:    begin d.unit[0] = U_MEM; d.unit[1] = U_MEM; d.unit[2] = U_FPU; end
      3'd4:    begin d.unit[0] = U_MEM; d.unit[1] = U_INT; d.unit[2] = U_BRN; end
      3'd5:    begin d.unit[0] = U_MEM; d.unit[1] = U_BRN; d.unit[2] = U_BRN; end
      3'd6:    begin d.unit[0] = U_BRN; d.unit[1] = U_BRN; d.unit[2] = U_BRN; end
      default: begin d.unit[0] = U_MEM; d.unit[1] = U_MEM; d.unit[2] = U_BRN; end
    endcase
    case (t[1:0])
      2'd0:    d.stop = 3'b000;
      2'd1:    d.stop = 3'b100;
      2'd2:    d.stop = 3'b001;
      default: d.stop = 3'b110;
    endcase
    d.legal = !((t[4:2] == 3'd6 && t[1]) || (t[4:2] == 3'd5 && t[1:0] == 2'd2));
    return d;
  endfunction
endpackage

// File: rtl/bndl_tmpl_dec.sv
module bndl_tmpl_dec
  import bndl_pkg::*;
(
  input  logic [BUNDLE_W-1:0]    bundle,
  output slot_t [SLOTS-1:0]      slots,
  output logic                   legal
);
  tmpl_t dec;

  always_comb dec = decode_tmpl(bundle[TMPL_W-1:0]);

  assign legal = dec.legal;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slots[s].bits = bundle[TMPL_W + s*SLOT_W +: SLOT_W];
    assign slots[s].unit = dec.unit[s];
    assign slots[s].stop = dec.stop[s];
  end
endmodule

// File: rtl/bndl_issue_sel.sv
module bndl_issue_sel #(
  parameter int LANES = 6,
  parameter int CW    = 4
) (
  input  logic [CW-1:0]    occ,
  input  logic [LANES-1:0] head_stop,
  output logic [CW-1:0]    take
);
  int lim;
  int tk;
  logic found;

  // issue the buffered head up to the lane count, cut just after the first stop
  always_comb begin
    lim   = (int'(occ) < LANES) ? int'(occ) : LANES;
    tk    = lim;
    found = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!found && i < lim && head_stop[i]) begin
        tk    = i + 1;
        found = 1'b1;
      end
    end
    take = CW'(tk);
  end
endmodule

// File: rtl/bndl_slot_buf.sv
module bndl_slot_buf
  import bndl_pkg::*;
#(
  parameter int DEPTH = 12,
  parameter int WR    = 6,
  parameter int LANES = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_cnt,
  input  slot_t [WR-1:0]    wr_slots,
  input  logic [CW-1:0]     take,
  output slot_t [LANES-1:0] head,
  output logic [CW-1:0]     occ
);
  localparam int IW = (WR > 1) ? $clog2(WR) : 1;
  localparam int MW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  slot_t         mem_q   [DEPTH];
  slot_t         mem_nxt [DEPTH];
  logic [CW-1:0] occ_q;
  logic [CW-1:0] occ_nxt;
  logic          upd;
  int            keep_i;
  int            tk_i;
  int            wc_i;

  // compacting buffer: survivors shift to the front, new slots append behind them
  always_comb begin
    tk_i   = int'(take);
    keep_i = int'(occ_q) - tk_i;
    wc_i   = wr_en ? int'(wr_cnt) : 0;
    for (int i = 0; i < DEPTH; i++) begin
      mem_nxt[i] = mem_q[i];
      if (i < keep_i) begin
        if (i + tk_i < DEPTH) mem_nxt[i] = mem_q[MW'(i + tk_i)];
      end else if (i - keep_i < wc_i) begin
        mem_nxt[i] = wr_slots[IW'(i - keep_i)];
      end
    end
    occ_nxt = flush ? '0 : CW'(keep_i + wc_i);
    upd     = (tk_i != 0) || (wc_i != 0);
  end

  always_ff @(posedge clk) begin
    if (upd) mem_q <= mem_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_nxt;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_head
    assign head[l] = mem_q[l];
  end

  assign occ = occ_q;
endmodule

// File: rtl/bndl_issue.sv
module bndl_issue
  import bndl_pkg::*;
#(
  parameter int LANES = 6,
  parameter int DEPTH = 12,
  parameter int BPC   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      fetch_valid,
  input  logic [BPC-1:0]            fetch_bmask,
  input  logic [BPC*BUNDLE_W-1:0]   fetch_bundles,
  output logic                      fetch_ready,
  output logic [LANES-1:0]          iss_valid,
  output logic [LANES*SLOT_W-1:0]   iss_slot,
  output logic [LANES*2-1:0]        iss_unit,
  output logic                      illegal_bundle
);
  localparam int WR = BPC * SLOTS;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (WR > 1) ? $clog2(WR) : 1;

  slot_t [SLOTS-1:0] dec_slots [BPC];
  logic  [BPC-1:0]   dec_legal;
  slot_t [WR-1:0]    wr_slots;
  logic  [CW-1:0]    wr_cnt;
  logic  [BPC-1:0]   bad;
  logic              accept;
  logic  [CW-1:0]    occ;
  logic  [CW-1:0]    sel_take;
  logic  [CW-1:0]    take_eff;
  slot_t [LANES-1:0] head;
  logic  [LANES-1:0] lane_stop;
  logic              illegal_q;
  logic              illegal_nxt;
  int                wpos;

  for (genvar b = 0; b < BPC; b++) begin : g_dec
    bndl_tmpl_dec u_dec (
      .bundle (fetch_bundles[b*BUNDLE_W +: BUNDLE_W]),
      .slots  (dec_slots[b]),
      .legal  (dec_legal[b])
    );
  end

  // pack the legal, present bundles oldest first
  always_comb begin
    wr_slots = '0;
    bad      = '0;
    wpos     = 0;
    for (int b = 0; b < BPC; b++) begin
      bad[b] = fetch_bmask[b] && !dec_legal[b];
      if (fetch_bmask[b] && dec_legal[b]) begin
        for (int s = 0; s < SLOTS; s++) wr_slots[IW'(wpos + s)] = dec_slots[b][s];
        wpos = wpos + SLOTS;
      end
    end
    wr_cnt = CW'(wpos);
  end

  assign fetch_ready = !flush && (int'(occ) <= DEPTH - WR);
  assign accept      = fetch_valid && fetch_ready;
  assign illegal_nxt = accept && (|bad);

  bndl_slot_buf #(.DEPTH(DEPTH), .WR(WR), .LANES(LANES), .CW(CW)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_en    (accept),
    .wr_cnt   (wr_cnt),
    .wr_slots (wr_slots),
    .take     (take_eff),
    .head     (head),
    .occ      (occ)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_stop[l]                = head[l].stop;
    assign iss_valid[l]                = !flush && (l < int'(sel_take));
    assign iss_slot[l*SLOT_W +: SLOT_W] = head[l].bits;
    assign iss_unit[l*2 +: 2]          = head[l].unit;
  end

  bndl_issue_sel #(.LANES(LANES), .CW(CW)) u_sel (
    .occ       (occ),
    .head_stop (lane_stop),
    .take      (sel_take)
  );

  assign take_eff = flush ? '0 : sel_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= illegal_nxt;
  end

  assign illegal_bundle = illegal_q;
endmodule

// File: rtl/bndl_issue_chk.sv
module bndl_issue_chk #(
  parameter int LANES = 6,
  parameter int DEPTH = 12,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic [LANES-1:0] iss_valid,
  input logic [LANES-1:0] lane_stop,
  input logic [CW-1:0]    occ,
  input logic             illegal_bundle
);
  // R7
  lanes_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((iss_valid & (iss_valid + LANES'(1))) == '0));

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (iss_valid == '0 && !fetch_ready));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (occ == '0));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) <= DEPTH);

  // R4
  illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_bundle |-> $past(fetch_valid && fetch_ready));

  for (genvar l = 0; l + 1 < LANES; l++) begin : g_cut
    // R6
    stop_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[l+1] |-> !lane_stop[l]);
  end
endmodule

bind bndl_issue bndl_issue_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flush          (flush),
  .fetch_valid    (fetch_valid),
  .fetch_ready    (fetch_ready),
  .iss_valid      (iss_valid),
  .lane_stop      (lane_stop),
  .occ            (occ),
  .illegal_bundle (illegal_bundle)
);

// File: tb/bndl_issue_tb.sv
module bndl_issue_tb;
  localparam int LANES = 6;
  localparam int SW    = 41;

  typedef struct {
    logic [SW-1:0] bits;
    logic [1:0]    unit;
    bit            stop;
  } exp_t;

  logic           clk;
  logic           rst_n;
  logic           flush;
  logic           fetch_valid;
  logic [1:0]     fetch_bmask;
  logic [255:0]   fetch_bundles;
  logic           fetch_ready;
  logic [5:0]     iss_valid;
  logic [245:0]   iss_slot;
  logic [11:0]    iss_unit;
  logic           illegal_bundle;

  int   n_cmp;
  int   n_bad;
  bit   done;
  exp_t exp_q[$];

  bndl_issue u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
    .fetch_bmask(fetch_bmask), .fetch_bundles(fetch_bundles), .fetch_ready(fetch_ready),
    .iss_valid(iss_valid), .iss_slot(iss_slot), .iss_unit(iss_unit),
    .illegal_bundle(illegal_bundle)
  );

  // 100 MHz: 10 ns period
  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // R2 model: {slot0, slot1, slot2} classes, M=0 I=1 F=2 B=3
  function automatic logic [5:0] units_of(input logic [2:0] p);
    case (p)
      3'd0: return {2'd0, 2'd1, 2'd1};
      3'd1: return {2'd0, 2'd0, 2'd1};
      3'd2: return {2'd0, 2'd2, 2'd1};
      3'd3: return {2'd0, 2'd0, 2'd2};
      3'd4: return {2'd0, 2'd1, 2'd3};
      3'd5: return {2'd0, 2'd3, 2'd3};
      3'd6: return {2'd3, 2'd3, 2'd3};
      default: return {2'd0, 2'd0, 2'd3};
    endcase
  endfunction

  // R3 model: bit s set = stop after slot s
  function automatic logic [2:0] stops_of(input logic [1:0] m);
    case (m)
      2'd0: return 3'b000;
      2'd1: return 3'b100;
      2'd2: return 3'b001;
      default: return 3'b110;
    endcase
  endfunction

  function automatic bit reserved(input logic [4:0] t);
    return (t == 5'd22) || (t == 5'd26) || (t == 5'd27);
  endfunction

  function automatic logic [SW-1:0] slot_val(input logic [31:0] tag, input int s);
    return {1'b0, tag, 8'(s)};
  endfunction

  // R1 layout: {slot2, slot1, slot0, template}
  function automatic logic [127:0] mk(input logic [4:0] t, input logic [31:0] tag);
    return {slot_val(tag, 2), slot_val(tag, 1), slot_val(tag, 0), t};
  endfunction

  task automatic push_bundle(input logic [127:0] b);
    logic [5:0] u;
    logic [2:0] st;
    exp_t e;
    if (!reserved(b[4:0])) begin
      u  = units_of(b[4:2]);
      st = stops_of(b[1:0]);
      for (int s = 0; s < 3; s++) begin
        e.bits = b[5 + s*SW +: SW];
        e.unit = u[5 - 2*s -: 2];
        e.stop = st[s];
        exp_q.push_back(e);
      end
    end
  endtask

  // driver: offers a handshake, records the expected slots once it is taken
  task automatic send(input logic [127:0] b0, input logic [127:0] b1, input logic [1:0] mask);
    @(negedge clk);
    fetch_valid   = 1'b1;
    fetch_bmask   = mask;
    fetch_bundles = {b1, b0};
    while (!fetch_ready) @(negedge clk);
    if (mask[0]) push_bundle(b0);
    if (mask[1]) push_bundle(b1);
    @(posedge clk);
    #1 fetch_valid = 1'b0;
  endtask

  task automatic cnt_chk(input int expv, input string tag);
    @(negedge clk);
    chk($countones(iss_valid) == expv, tag, 64'($countones(iss_valid)), 64'(expv));
  endtask

  // monitor: compares issued lanes against the scoreboard, oldest first
  always @(negedge clk) begin
    if (rst_n && !flush && !done) begin
      int nv;
      exp_t e;
      nv = $countones(iss_valid);
      for (int l = 0; l < LANES; l++) begin
        if (l > 0 && iss_valid[l] && !iss_valid[l-1])
          chk(1'b0, "R7 lanes not contiguous", 64'(iss_valid), 64'(0));
        if (iss_valid[l]) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected issue", 64'(l), 64'(0));
          end else begin
            e = exp_q.pop_front();
            chk(iss_slot[l*SW +: SW] == e.bits, "R1 slot bits in order",
                64'(iss_slot[l*SW +: SW]), 64'(e.bits));
            chk(iss_unit[l*2 +: 2] == e.unit, "R2 unit class",
                64'(iss_unit[l*2 +: 2]), 64'(e.unit));
            if (e.stop)
              chk(l == nv - 1, "R6 issue crossed a stop", 64'(nv), 64'(l + 1));
          end
        end
      end
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; flush = 1'b0; fetch_valid = 1'b0;
    fetch_bmask = '0; fetch_bundles = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(iss_valid == '0, "R10 reset lanes", 64'(iss_valid), 64'(0));
    chk(fetch_ready, "R10 reset ready", 64'(fetch_ready), 64'(1));
    chk(!illegal_bundle, "R10 reset error", 64'(illegal_bundle), 64'(0));

    // R6 one group spans two bundles; R11 issue right after the edge
    send(mk(5'd0, 32'h100), mk(5'd4, 32'h101), 2'b11);
    cnt_chk(6, "R6 cross-bundle group of six");
    cnt_chk(0, "R11 nothing left");

    // R3 stop after slot 0 of the older bundle
    send(mk(5'd10, 32'h200), mk(5'd12, 32'h201), 2'b11);
    cnt_chk(1, "R3 cut after slot 0");
    cnt_chk(5, "R6 remainder issues later");

    // R5 single bundle 0
    send(mk(5'd17, 32'h300), '0, 2'b01);
    cnt_chk(3, "R5 single bundle");
    cnt_chk(0, "R5 no phantom bundle");

    // R5 only bundle 1 present, R3 mode 3 stops after slots 1 and 2
    send(mk(5'd26, 32'h3ff), mk(5'd31, 32'h400), 2'b10);
    cnt_chk(2, "R3 stop after slot 1");
    chk(!illegal_bundle, "R5 absent bundle not decoded", 64'(illegal_bundle), 64'(0));
    cnt_chk(1, "R3 stop after slot 2");

    send(mk(5'd25, 32'h500), '0, 2'b01);
    cnt_chk(3, "R2 all-branch bundle");

    // R4 reserved templates
    send(mk(5'd26, 32'h600), '0, 2'b01);
    @(negedge clk);
    chk(illegal_bundle, "R4 error pulse", 64'(illegal_bundle), 64'(1));
    chk(iss_valid == '0, "R4 nothing issued", 64'(iss_valid), 64'(0));
    @(negedge clk);
    chk(!illegal_bundle, "R4 pulse one cycle", 64'(illegal_bundle), 64'(0));
    send(mk(5'd27, 32'h700), mk(5'd25, 32'h701), 2'b11);
    @(negedge clk);
    chk(illegal_bundle, "R4 error with good partner", 64'(illegal_bundle), 64'(1));
    chk($countones(iss_valid) == 3, "R4 partner still issues", 64'($countones(iss_valid)), 64'(3));
    send(mk(5'd22, 32'h800), '0, 2'b01);
    @(negedge clk);
    chk(illegal_bundle, "R4 template 22", 64'(illegal_bundle), 64'(1));

    // R8 backpressure: eleven buffered after two handshakes
    send(mk(5'd10, 32'h900), mk(5'd10, 32'h901), 2'b11);
    send(mk(5'd10, 32'h902), mk(5'd10, 32'h903), 2'b11);
    @(negedge clk);
    chk(!fetch_ready, "R8 ready low when full", 64'(fetch_ready), 64'(0));
    send(mk(5'd1, 32'h904), mk(5'd0, 32'h905), 2'b11);
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all delivered after stall", 64'(exp_q.size()), 64'(0));
    chk(fetch_ready, "R8 ready back", 64'(fetch_ready), 64'(1));

    // R9 flush drops the unissued tail of a group
    send(mk(5'd10, 32'ha00), '0, 2'b01);
    cnt_chk(1, "R9 first part issued");
    @(posedge clk);
    #1 flush = 1'b1;
    exp_q.delete();
    @(negedge clk);
    chk(iss_valid == '0, "R9 no issue during flush", 64'(iss_valid), 64'(0));
    chk(!fetch_ready, "R9 ready low during flush", 64'(fetch_ready), 64'(0));
    @(posedge clk);
    #1 flush = 1'b0;
    @(negedge clk);
    chk(iss_valid == '0, "R9 buffer empty", 64'(iss_valid), 64'(0));
    chk(fetch_ready, "R9 ready after flush", 64'(fetch_ready), 64'(1));
    send(mk(5'd0, 32'hb00), '0, 2'b01);
    cnt_chk(3, "R9 fresh bundle after flush");

    // random stream against the scoreboard
    for (int k = 0; k < 300; k++) begin
      send(mk(5'($urandom_range(0, 31)), 32'h1000 + k),
           mk(5'($urandom_range(0, 31)), 32'h8000 + k),
           2'($urandom_range(1, 3)));
    end
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R6 random stream drained", 64'(exp_q.size()), 64'(0));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule